// File: doc/BRIEF.md
# Triplicated Slow-to-Fast Event Synchronizer

This block moves a single-bit event from a slow sending clock domain into a faster receiving domain. It is built as three redundant lanes so that a single upset lane cannot create or lose an event. The sending side presents three copies of its event line. In each lane, the rising edge of that line is caught by a flop whose clock is the send line itself and whose data input is tied to 1. The caught level then passes through receiver-clocked stages. Once the second of those stages holds the event, the capture flop is cleared asynchronously, so every send edge gives one bounded level in the receiver domain.

The three lane levels feed three separate majority voters. Each voter has its own rising-edge detector. The result is three copies of a one-cycle pulse, all produced from the same vote. Downstream triplicated logic can then take one copy per lane. The sender must space its edges at least four receiver cycles apart. An edge that arrives while a lane's capture flop is held clear can be lost.

Top module: `tmr_event_sync`

## Requirements
- R1: While reset is high, and in the cycle after reset is sampled, every pulse output is 0. An event that is in flight when reset arrives produces no pulse.
- R2: Suppose all three send lines rise between receiver edges k and k+1. Then all three pulse outputs are 1 during the cycle that follows receiver edge k+5 and are 0 in the cycles around it.
- R3: A pulse output is never 1 in two consecutive receiver cycles.
- R4: A lane's capture flop is clear whenever its second receiver stage holds the event. Each accepted event keeps the lane's received level at 1 for exactly two receiver cycles, which re-arms the lane for the next edge.
- R5: Rising edges on any two lanes in the same gap between receiver edges produce a pulse. A rising edge on one lane alone produces none.
- R6: If one lane is stuck at 0, either because its send line stays low or because its received level is held at 0, every event on the other two lanes still produces exactly one pulse with the R2 timing.
- R7: If one lane's received level is stuck at 1, the outputs stay 0 while idle. Every event on the other two lanes still produces exactly one pulse with the R2 timing.
- R8: Send edges spaced four receiver cycles apart each produce their own pulse, with the R2 timing applied to each edge.
- R9: Only rising send edges count. A send line held high for many cycles, or falling, produces no further pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_rx_i | input | 1 | Receiver-domain clock |
| rst_rx_i | input | 1 | Synchronous active-high reset; also clears the capture flops asynchronously |
| send_i | input | 3 | Triplicated event lines from the sending domain; a rising edge is an event |
| pulse_o | output | 3 | Triplicated voted one-cycle event pulses |

## Verification
The hardest case to reach from the ports is a lane whose receiver-side level is wrong while the other lanes work normally. Upsets of that kind cannot be driven through the send lines. The stimulus therefore overrides one lane's received level to 0 or to 1 during idle periods. It then fires events on the healthy lanes at the minimum spacing and compares every cycle with a queue-based model. Single-lane edges, long high levels on the send lines, and a reset that lands in the middle of an event cover the remaining corners.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int unsigned LANES = 3;

  function automatic logic maj3(input logic [LANES-1:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction
endpackage

// File: rtl/evt_capture_lane.sv
module evt_capture_lane (
  input  logic clk_rx_i,
  input  logic rst_rx_i,
  input  logic snd_i,
  output logic rcv_o
);
  logic cap_q;
  logic stg1_q;
  logic stg2_q;
  logic rcv_q;
  logic clr_w;
  logic rcv_w;

  // capture is released only when neither reset nor the second stage holds it
  assign clr_w = stg2_q | rst_rx_i;

  always_ff @(posedge snd_i or posedge clr_w) begin
    if (clr_w) cap_q <= 1'b0;
    else       cap_q <= 1'b1;
  end

  always_ff @(posedge clk_rx_i) begin
    if (rst_rx_i) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
      rcv_q  <= 1'b0;
    end else begin
      stg1_q <= cap_q;
      stg2_q <= stg1_q;
      rcv_q  <= stg2_q;
    end
  end

  assign rcv_w = rcv_q;
  assign rcv_o = rcv_w;

  // R4: capture flop held clear while stage two carries the event
  p_capture_cleared_r4: assert property (@(posedge clk_rx_i) disable iff (rst_rx_i)
    stg2_q |-> !cap_q);

  // R4: received level stays up for a second cycle
  p_rcv_hold_r4: assert property (@(posedge clk_rx_i) disable iff (rst_rx_i)
    $rose(rcv_q) |=> rcv_q);

  // R4: received level never exceeds two cycles
  p_rcv_drop_r4: assert property (@(posedge clk_rx_i) disable iff (rst_rx_i)
    (rcv_q && $past(rcv_q)) |=> !rcv_q);
endmodule

// File: rtl/evt_vote_edge.sv
module evt_vote_edge
  import tmr_evt_pkg::*;
(
  input  logic             clk_rx_i,
  input  logic             rst_rx_i,
  input  logic [LANES-1:0] lanes_i,
  output logic             pulse_o
);
  logic vote_q;
  logic vote_d;
  logic pulse_q;

  always_ff @(posedge clk_rx_i) begin
    if (rst_rx_i) begin
      vote_q  <= 1'b0;
      vote_d  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      vote_q  <= maj3(lanes_i);
      vote_d  <= vote_q;
      pulse_q <= vote_q & ~vote_d;
    end
  end

  assign pulse_o = pulse_q;

  // R1: output quiet after reset is sampled
  p_reset_quiet_r1: assert property (@(posedge clk_rx_i)
    rst_rx_i |=> !pulse_q);

  // R3: never two consecutive pulse cycles
  p_pulse_single_r3: assert property (@(posedge clk_rx_i) disable iff (rst_rx_i)
    pulse_q |=> !pulse_q);

  // R5: a pulse needs a lane quorum two cycles earlier
  p_pulse_quorum_r5: assert property (@(posedge clk_rx_i) disable iff (rst_rx_i)
    $rose(pulse_q) |-> $past($countones(lanes_i) >= 2, 2));
endmodule

// File: rtl/tmr_event_sync.sv
module tmr_event_sync
  import tmr_evt_pkg::*;
(
  input  logic             clk_rx_i,
  input  logic             rst_rx_i,
  input  logic [LANES-1:0] send_i,
  output logic [LANES-1:0] pulse_o
);
  logic [LANES-1:0] lane_rcv;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    evt_capture_lane u_lane (
      .clk_rx_i (clk_rx_i),
      .rst_rx_i (rst_rx_i),
      .snd_i    (send_i[i]),
      .rcv_o    (lane_rcv[i])
    );
  end

  for (genvar i = 0; i < LANES; i++) begin : g_vote
    evt_vote_edge u_vote (
      .clk_rx_i (clk_rx_i),
      .rst_rx_i (rst_rx_i),
      .lanes_i  (lane_rcv),
      .pulse_o  (pulse_o[i])
    );
  end
endmodule

// File: tb/test_tmr_event_sync.sv
module test_tmr_event_sync;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] send = 3'b000;
  logic [2:0] pulse;

  int    checks = 0;
  int    errors = 0;
  int    cyc    = 0;
  bit    done   = 0;
  string req    = "R1";
  int    expq[$];
  logic [2:0] healthy = 3'b111;
  int    stuck_hi = 0;

  tmr_event_sync i_tmr_event_sync (
    .clk_rx_i (clk),
    .rst_rx_i (rst),
    .send_i   (send),
    .pulse_o  (pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) expq.delete();
  end

  // reference comparison once per cycle, away from the active edge
  always @(negedge clk) begin
    logic exp_v;
    exp_v = 1'b0;
    if (expq.size() > 0 && expq[0] == cyc) begin
      exp_v = 1'b1;
      void'(expq.pop_front());
    end
    checks++;
    if (pulse !== {3{exp_v}}) begin
      errors++;
      $display("FAIL %s cycle %0d pulse=%b expected=%b", req, cyc, pulse, {3{exp_v}});
    end
  end

  // raise the lanes in mask at a falling edge, hold, then drop, then idle
  task automatic fire(input logic [2:0] mask, input int hold, input int gap);
    @(negedge clk);
    if ($countones(mask & healthy) + stuck_hi >= 2) expq.push_back(cyc + 5);
    send = send | mask;
    repeat (hold) @(negedge clk);
    send = send & ~mask;
    repeat (gap) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    req = "R1";
    idle(3);
    rst = 1'b0;
    idle(3);

    req = "R2";
    fire(3'b111, 1, 8);
    fire(3'b111, 2, 10);

    req = "R5";
    fire(3'b011, 1, 8);
    fire(3'b101, 1, 8);
    fire(3'b010, 1, 8);
    fire(3'b100, 2, 8);

    req = "R4 R8";
    for (int n = 0; n < 5; n++) fire(3'b111, 1, 3);
    idle(8);

    req = "R9";
    fire(3'b111, 20, 8);

    req = "R6";
    healthy = 3'b110;
    for (int n = 0; n < 3; n++) fire(3'b110, 1, 3);
    idle(8);
    healthy = 3'b111;
    force i_tmr_event_sync.g_lane[2].u_lane.rcv_w = 1'b0;
    healthy = 3'b011;
    for (int n = 0; n < 3; n++) fire(3'b111, 1, 3);
    idle(8);
    release i_tmr_event_sync.g_lane[2].u_lane.rcv_w;
    healthy = 3'b111;
    idle(4);

    req = "R7";
    force i_tmr_event_sync.g_lane[1].u_lane.rcv_w = 1'b1;
    healthy = 3'b101;
    stuck_hi = 1;
    idle(6);
    for (int n = 0; n < 3; n++) fire(3'b101, 1, 3);
    idle(4);
    fire(3'b111, 1, 8);
    release i_tmr_event_sync.g_lane[1].u_lane.rcv_w;
    stuck_hi = 0;
    healthy = 3'b111;
    idle(6);

    req = "R1";
    fire(3'b111, 1, 2);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(10);

    req = "R2";
    fire(3'b111, 1, 8);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule